// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block takes four asynchronous external interrupt request pins and turns each into a clean, per-line request for the rest of an interrupt controller. Each pin is first brought into the clock domain through a chain of flip-flops. It is then interpreted according to its own 2-bit sense code, which selects one of four modes: high-level, low-level, rising-edge or falling-edge detection. In the edge modes the detected transition is held in a sticky flag until software clears it. In the level modes the request simply tracks the synchronised pin.

All configuration lives in one 32-bit control word behind a minimal register port, which is a write strobe with write data and a combinational read-back. The control word holds four things:
- the four sense codes;
- a per-line enable;
- a global enable for the external lines;
- a routing bit for line 0.

Per-line bits acknowledge a held edge event when software writes 1 to them. When read, those same bits show whether an edge event is currently held.

Line 0 is the critical-class line. When its routing bit is set, its request leaves on the critical output. When the bit is clear, the request joins lines 1 to 3 on the main-class output.

Top module: `extirq_conditioner`

## Requirements
- R1: Each line n takes its sense code from control bits [23-2n:22-2n], so line 0 uses [23:22] and line 3 uses [17:16]. The codes are: 0 = active-high level, 1 = rising edge, 2 = falling edge, 3 = active-low level.
- R2: A level-sensed line is not latched. Its request follows the synchronised pin: a pin change driven between clock edges shows on `line_req` after the second following rising clock edge, and not after the first.
- R3: An edge-sensed line latches the selected transition. Its request rises after the third rising clock edge following the pin change. It stays high after the pin returns to its idle level, until it is cleared.
- R4: Writing 1 to control bit 27-n clears the held edge event of line n, so line 3 uses bit 24 and line 0 uses bit 27. Writing 0 there has no effect. Reading bit 27-n returns the held edge flag of line n.
- R5: Control bit 11-n enables line n. While the bit is 0 the line gives no request, but an edge is still latched and is visible at read bit 27-n.
- R6: Control bit 12 is the master external enable. While it is 0, no line gives a request.
- R7: Control bit 0 steers line 0. When it is 1, line 0's request appears on `crit_req` and not on `main_req`. When it is 0, the request appears on `main_req` and `crit_req` stays low. `main_req` is also high whenever any of lines 1 to 3 requests.
- R8: If a new edge is detected in the same cycle that a clear of that line is written, the new edge wins and the flag stays set.
- R9: After reset the control word reads 0 and `line_req`, `crit_req` and `main_req` are all low.
- R10: After a write of all ones, the control word reads 0x00FF1F01. Sense, enable, master and routing bits read as written; bits 27-24 read the edge flags; every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read-back with edge flags |
| irq_pin | input | 4 | Asynchronous external request pins, bit n = line n |
| line_req | output | 4 | Conditioned per-line request, bit n = line n |
| crit_req | output | 1 | Critical-class request from line 0 |
| main_req | output | 1 | Main-class request from lines 1-3 and, if steered, line 0 |

## Verification
The collision that matters is between an edge being latched and a software clear of the same line's flag in the same clock cycle. The bench sets a line's flag from an earlier rising edge. It then drives a fresh rising edge on the pin and times the clear write so that its strobe is sampled on exactly the edge where the synchroniser presents the new transition to the detector. The result is judged through the read-back flag bit and the line's request, both of which must stay high. A clear written afterwards, with no edge present, must then drop both, which shows the clear itself works.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int CTRL_W     = 32;
    localparam int NUM_LINES  = 4;
    localparam int MASTER_BIT = 12;
    localparam int ROUTE_BIT  = 0;

    typedef enum logic [1:0] {
        SENSE_LEVEL_HI = 2'd0,
        SENSE_RISE     = 2'd1,
        SENSE_FALL     = 2'd2,
        SENSE_LEVEL_LO = 2'd3
    } sense_e;

    typedef struct packed {
        sense_e sense;
        logic   enable;
    } line_cfg_t;

    typedef struct packed {
        logic master_en;
        logic crit_normal;
    } glob_cfg_t;

    function automatic int sense_lsb(input int n);
        return 22 - 2 * n;
    endfunction

    function automatic int enable_bit(input int n);
        return 11 - n;
    endfunction

    function automatic int clear_bit(input int n);
        return 27 - n;
    endfunction

    function automatic logic is_edge_mode(input sense_e s);
        return (s == SENSE_RISE) || (s == SENSE_FALL);
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/extirq_edge_latch.sv
module extirq_edge_latch
    import extirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_e sense,
    input  logic   level_in,
    input  logic   clr,
    output logic   pend
);
    logic prev_q;
    logic hit;
    logic pend_q;

    always_comb begin
        unique case (sense)
            SENSE_RISE: hit = level_in & ~prev_q;
            SENSE_FALL: hit = ~level_in & prev_q;
            default:    hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= level_in;
            // a fresh edge takes priority over a simultaneous clear
            pend_q <= (pend_q & ~clr) | hit;
        end
    end

    assign pend = pend_q;

    p_pend_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

    p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(level_in != prev_q));

endmodule

// File: rtl/extirq_ctrl_reg.sv
module extirq_ctrl_reg
    import extirq_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [CTRL_W-1:0]               wdata,
    input  logic [NUM_LINES-1:0]            pend,
    output line_cfg_t [NUM_LINES-1:0]       cfg,
    output glob_cfg_t                       glob,
    output logic [NUM_LINES-1:0]            clr,
    output logic [CTRL_W-1:0]               rdata
);
    line_cfg_t [NUM_LINES-1:0] cfg_q;
    glob_cfg_t                 glob_q;
    logic                      unused_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            glob_q <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                cfg_q[n].sense  <= sense_e'(wdata[sense_lsb(n) +: 2]);
                cfg_q[n].enable <= wdata[enable_bit(n)];
            end
            glob_q.master_en   <= wdata[MASTER_BIT];
            glob_q.crit_normal <= wdata[ROUTE_BIT];
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            clr[n] = wr_en & wdata[clear_bit(n)];
        end
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            rdata[sense_lsb(n) +: 2] = cfg_q[n].sense;
            rdata[enable_bit(n)]     = cfg_q[n].enable;
            rdata[clear_bit(n)]      = pend[n];
        end
        rdata[MASTER_BIT] = glob_q.master_en;
        rdata[ROUTE_BIT]  = glob_q.crit_normal;
    end

    assign unused_wdata = ^wdata;
    assign cfg  = cfg_q;
    assign glob = glob_q;

    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q) && $stable(glob_q));

endmodule

// File: rtl/extirq_conditioner.sv
module extirq_conditioner
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [CTRL_W-1:0]    reg_wdata,
    output logic [CTRL_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] irq_pin,
    output logic [NUM_LINES-1:0] line_req,
    output logic                 crit_req,
    output logic                 main_req
);
    line_cfg_t [NUM_LINES-1:0] cfg;
    glob_cfg_t                 glob;
    logic [NUM_LINES-1:0]      clr;
    logic [NUM_LINES-1:0]      pend;
    logic [NUM_LINES-1:0]      pin_sync;
    logic [NUM_LINES-1:0]      active;

    extirq_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .wdata (reg_wdata),
        .pend  (pend),
        .cfg   (cfg),
        .glob  (glob),
        .clr   (clr),
        .rdata (reg_rdata)
    );

    extirq_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_pin),
        .q   (pin_sync)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        extirq_edge_latch u_edge (
            .clk      (clk),
            .rst      (rst),
            .sense    (cfg[n].sense),
            .level_in (pin_sync[n]),
            .clr      (clr[n]),
            .pend     (pend[n])
        );

        // level modes: code bit 0 selects inversion (0 = high, 3 = low)
        assign active[n] = is_edge_mode(cfg[n].sense) ? pend[n]
                         : (pin_sync[n] ^ cfg[n].sense[0]);

        assign line_req[n] = active[n] & cfg[n].enable & glob.master_en;

        p_enable_gate_r5: assert property (@(posedge clk) disable iff (rst)
            !reg_rdata[enable_bit(n)] |-> !line_req[n]);
    end

    assign crit_req = line_req[0] & glob.crit_normal;
    assign main_req = (|line_req[NUM_LINES-1:1]) | (line_req[0] & ~glob.crit_normal);

    p_master_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[MASTER_BIT] |-> (line_req == '0));

    p_crit_route_r7: assert property (@(posedge clk) disable iff (rst)
        crit_req |-> (reg_rdata[ROUTE_BIT] && line_req[0]));

    p_crit_excl_r7: assert property (@(posedge clk) disable iff (rst)
        (line_req[NUM_LINES-1:1] == '0) |-> !(crit_req && main_req));

endmodule

// File: tb/tb_extirq_conditioner.sv
`timescale 1ns/1ps
module tb_extirq_conditioner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_pin = '0;
    logic [3:0]  line_req;
    logic        crit_req;
    logic        main_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    extirq_conditioner dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_pin   (irq_pin),
        .line_req  (line_req),
        .crit_req  (crit_req),
        .main_req  (main_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [31:0] v);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic quiesce(input logic [31:0] cfg);
        irq_pin = '0;
        wait_edges(4);
        reg_write(cfg | 32'h0F00_0000);
    endtask

    task automatic t_reset;
        check("R9 rdata", reg_rdata, 32'h0);
        check("R9 line_req", {28'h0, line_req}, 32'h0);
        check("R9 crit/main", {30'h0, crit_req, main_req}, 32'h0);
    endtask

    task automatic t_level_high;
        quiesce(32'h0000_1400);          // line1 code 0, en bit 10, master
        irq_pin[1] = 1'b1;
        wait_edges(1);
        check("R2 level-hi latency 1", {28'h0, line_req}, 32'h0);
        wait_edges(1);
        check("R1 R2 level-hi asserted", {28'h0, line_req}, 32'h2);
        check("R7 main from line1", {31'h0, main_req}, 32'h1);
        irq_pin[1] = 1'b0;
        wait_edges(2);
        check("R2 level-hi follows pin low", {28'h0, line_req}, 32'h0);
    endtask

    task automatic t_level_low;
        quiesce(32'h000C_1200);          // line2 code 3 at [19:18], en bit 9
        check("R1 level-lo idle pin low", {28'h0, line_req}, 32'h4);
        irq_pin[2] = 1'b1;
        wait_edges(2);
        check("R2 level-lo pin high", {28'h0, line_req}, 32'h0);
    endtask

    task automatic t_rise;
        quiesce(32'h0001_1100);          // line3 code 1 at [17:16], en bit 8
        irq_pin[3] = 1'b1;
        wait_edges(2);
        check("R3 rise latency 2", {28'h0, line_req}, 32'h0);
        wait_edges(1);
        check("R3 rise latched", {28'h0, line_req}, 32'h8);
        irq_pin[3] = 1'b0;
        wait_edges(4);
        check("R3 held after pin idle", {28'h0, line_req}, 32'h8);
        check("R4 flag readback bit24", {31'h0, reg_rdata[24]}, 32'h1);
        reg_write(32'h0001_1100);
        check("R4 write zero no effect", {28'h0, line_req}, 32'h8);
        reg_write(32'h0101_1100);
        check("R4 w1c clears", {28'h0, line_req}, 32'h0);
        check("R4 flag readback cleared", {31'h0, reg_rdata[24]}, 32'h0);
    endtask

    task automatic t_fall_route;
        irq_pin = 4'h1;
        wait_edges(4);
        reg_write(32'h0F80_1801);        // line0 code 2 at [23:22], en bit 11, route
        irq_pin[0] = 1'b0;
        wait_edges(2);
        check("R3 fall latency 2", {31'h0, crit_req}, 32'h0);
        wait_edges(1);
        check("R7 crit on fall", {30'h0, crit_req, main_req}, 32'h2);
        reg_write(32'h0080_1800);
        check("R7 steered to main", {30'h0, crit_req, main_req}, 32'h1);
        reg_write(32'h0880_1800);
        check("R4 line0 bit27 clear", {30'h0, crit_req, main_req}, 32'h0);
    endtask

    task automatic t_enable;
        quiesce(32'h0001_1000);          // line3 rise, enable off
        irq_pin[3] = 1'b1;
        wait_edges(3);
        check("R5 disabled no req", {28'h0, line_req}, 32'h0);
        check("R5 still latched", {31'h0, reg_rdata[24]}, 32'h1);
        reg_write(32'h0001_1100);
        check("R5 enable shows held edge", {28'h0, line_req}, 32'h8);
    endtask

    task automatic t_master;
        quiesce(32'h0000_0400);          // line1 level-hi enabled, master off
        irq_pin[1] = 1'b1;
        wait_edges(3);
        check("R6 master off", {28'h0, line_req}, 32'h0);
        reg_write(32'h0000_1400);
        check("R6 master on", {28'h0, line_req}, 32'h2);
    endtask

    task automatic t_same_cycle;
        quiesce(32'h0001_1100);
        irq_pin[3] = 1'b1;
        wait_edges(4);
        irq_pin[3] = 1'b0;
        wait_edges(4);
        check("R8 precondition flag", {31'h0, reg_rdata[24]}, 32'h1);
        irq_pin[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_write(32'h0101_1100);        // strobe lands with the new edge
        check("R8 set wins flag", {31'h0, reg_rdata[24]}, 32'h1);
        check("R8 set wins req", {28'h0, line_req}, 32'h8);
        reg_write(32'h0101_1100);
        check("R8 later clear works", {28'h0, line_req}, 32'h0);
    endtask

    task automatic t_readback;
        irq_pin = '0;
        wait_edges(4);
        reg_write(32'hFFFF_FFFF);
        check("R10 readback mask", reg_rdata, 32'h00FF_1F01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall_route();
        t_enable();
        t_master();
        t_same_cycle();
        t_readback();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule